// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is a register file that accepts one write and serves two independent reads in every clock cycle. It is meant for fabric whose memories offer one write port and one read port. Storage is held in two identical copies. Every write goes to both copies in the same clock edge, and each read port has its own copy.

Writes are synchronous: a location is updated on the rising clock edge when the write enable is high. Reads are combinational. A read port's data follows its address with no clock edge in between. By default, a read that hits the location being written in the same cycle returns the contents from before that write. A parameter can instead select write-through, where such a read returns the incoming write data at once.

The depth is meant to be a multiple of 16 from 16 to 256 entries. The width can be 1 to 32 bits. The synchronous, active-high reset blocks writes while it is asserted but leaves the stored contents alone. No location has a defined value until it has been written.

Top module: `dual_read_regfile`

## Requirements
- R1: In a single cycle, both read ports return the contents of their own addresses, which may differ.
- R2: When `wr_en` is high on a rising edge and `rst` is low, `wr_data` is stored at `wr_addr`. From the next cycle on, both read ports return the new value for that address.
- R3: Read data changes combinationally when the read address changes, without waiting for a clock edge.
- R4: With `BYP_MODE` = `BYP_NONE` (the default), a read whose address equals `wr_addr` while `wr_en` is high returns the value stored before that write.
- R5: With `BYP_MODE` = `BYP_WRITE_THROUGH`, a read whose address equals `wr_addr` while `wr_en` is high and `rst` is low returns `wr_data` in the same cycle.
- R6: While `wr_en` is low, the values on `wr_addr` and `wr_data` change no stored location.
- R7: While `rst` is high, a write request has no effect on storage.
- R8: All `DEPTH` locations, addressed 0 to `DEPTH-1`, hold independent values.
- R9: The two copies always agree: both ports return the same data when they read the same written address.
- R10: Asserting `rst` does not clear or change any stored location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| wr_en | input | 1 | Write enable |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | WIDTH | Write data |
| rd0_addr | input | $clog2(DEPTH) | Read port 0 address |
| rd0_data | output | WIDTH | Read port 0 data (combinational) |
| rd1_addr | input | $clog2(DEPTH) | Read port 1 address |
| rd1_data | output | WIDTH | Read port 1 data (combinational) |

## Verification
On every cycle, the bound checker verifies four behaviours:
- the two copies agree whenever both ports read the same written address;
- a write is visible on the next cycle;
- in the default mode, a colliding read stays at the old value;
- in write-through mode, a colliding read returns the write data.

The remaining behaviours are covered only by the directed scenarios in the bench:
- writes are ignored during reset, and reset leaves the contents intact;
- all locations are independent across the full address range;
- read data follows a change of address within one clock phase.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    typedef enum logic [0:0] {
        BYP_NONE          = 1'b0,
        BYP_WRITE_THROUGH = 1'b1
    } bypass_mode_e;

    localparam int unsigned NUM_RD_PORTS = 2;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic logic addr_hit(input logic en, input logic [15:0] a, input logic [15:0] b);
        return en && (a == b);
    endfunction

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 16,
    localparam int unsigned AW = rfp_pkg::addr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned AW = 5,
    parameter rfp_pkg::bypass_mode_e BYP_MODE = rfp_pkg::BYP_NONE
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    input  logic [WIDTH-1:0] bank_data,
    output logic [WIDTH-1:0] rd_data
);
    localparam logic BYP_ON = (BYP_MODE == rfp_pkg::BYP_WRITE_THROUGH);

    logic hit;

    always_comb begin
        hit = rfp_pkg::addr_hit(wr_en, 16'(wr_addr), 16'(rd_addr));
        rd_data = (BYP_ON && hit) ? wr_data : bank_data;
    end

endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 16,
    parameter rfp_pkg::bypass_mode_e BYP_MODE = rfp_pkg::BYP_NONE,
    localparam int unsigned AW = rfp_pkg::addr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd0_addr,
    output logic [WIDTH-1:0] rd0_data,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd1_data
);
    localparam int unsigned NP = rfp_pkg::NUM_RD_PORTS;

    typedef struct packed {
        logic             en;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
    } wr_req_t;

    wr_req_t          wreq;
    logic [AW-1:0]    raddr [NP];
    logic [WIDTH-1:0] bdata [NP];
    logic [WIDTH-1:0] rdata [NP];

    always_comb begin
        wreq.en   = wr_en && !rst;
        wreq.addr = wr_addr;
        wreq.data = wr_data;
    end

    assign raddr[0] = rd0_addr;
    assign raddr[1] = rd1_addr;
    assign rd0_data = rdata[0];
    assign rd1_data = rdata[1];

    for (genvar p = 0; p < NP; p++) begin : g_port
        rf_bank #(
            .DEPTH(DEPTH),
            .WIDTH(WIDTH)
        ) u_bank (
            .clk    (clk),
            .wr_en  (wreq.en),
            .wr_addr(wreq.addr),
            .wr_data(wreq.data),
            .rd_addr(raddr[p]),
            .rd_data(bdata[p])
        );

        rf_read_mux #(
            .WIDTH   (WIDTH),
            .AW      (AW),
            .BYP_MODE(BYP_MODE)
        ) u_mux (
            .wr_en    (wreq.en),
            .wr_addr  (wreq.addr),
            .wr_data  (wreq.data),
            .rd_addr  (raddr[p]),
            .bank_data(bdata[p]),
            .rd_data  (rdata[p])
        );
    end

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 16,
    parameter rfp_pkg::bypass_mode_e BYP_MODE = rfp_pkg::BYP_NONE,
    localparam int unsigned AW = rfp_pkg::addr_bits(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic [AW-1:0]    rd0_addr,
    input logic [WIDTH-1:0] rd0_data,
    input logic [AW-1:0]    rd1_addr,
    input logic [WIDTH-1:0] rd1_data
);
    localparam logic WT = (BYP_MODE == rfp_pkg::BYP_WRITE_THROUGH);

    logic [DEPTH-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (wr_en) begin
            seen[wr_addr] <= 1'b1;
        end
    end

    p_copies_agree_r9: assert property (@(posedge clk) disable iff (rst)
        (rd0_addr == rd1_addr && seen[rd0_addr]) |-> (rd0_data == rd1_data));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((rd0_addr != $past(wr_addr)) || (rd0_data == $past(wr_data))
                   || (WT && wr_en && wr_addr == rd0_addr)));

    p_old_on_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (!WT && wr_en && wr_addr == rd0_addr && $past(rd0_addr) == rd0_addr && !$past(wr_en))
        |-> $stable(rd0_data));

    p_write_through_r5: assert property (@(posedge clk) disable iff (rst)
        (WT && wr_en && wr_addr == rd1_addr) |-> (rd1_data == wr_data));

endmodule

bind dual_read_regfile rf_checker #(
    .DEPTH   (DEPTH),
    .WIDTH   (WIDTH),
    .BYP_MODE(BYP_MODE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd0_addr(rd0_addr),
    .rd0_data(rd0_data),
    .rd1_addr(rd1_addr),
    .rd1_data(rd1_data)
);

// File: tb/sim_dual_read_regfile.sv
`timescale 1ns/1ps
module sim_dual_read_regfile;
    localparam int DEPTH = 32;
    localparam int WIDTH = 16;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [AW-1:0] rd0_addr = '0;
    logic [AW-1:0] rd1_addr = '0;
    logic [WIDTH-1:0] a0, a1, b0, b1;

    logic [WIDTH-1:0] ref_mem [DEPTH];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_read_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_addr(rd0_addr), .rd0_data(a0), .rd1_addr(rd1_addr), .rd1_data(a1));

    dual_read_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH),
                        .BYP_MODE(rfp_pkg::BYP_WRITE_THROUGH)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_addr(rd0_addr), .rd0_data(b0), .rd1_addr(rd1_addr), .rd1_data(b1));

    task automatic chk(input bit ok, input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!rst) ref_mem[a] = d;
    endtask

    // R8, R1, R2: fill every location, read two different addresses at once
    task automatic t_fill_all();
        for (int i = 0; i < DEPTH; i++) do_write(AW'(i), WIDTH'(i * 16'h0101) ^ 16'h5A3C);
        for (int i = 0; i < DEPTH; i++) begin
            rd0_addr = AW'(i); rd1_addr = AW'(DEPTH - 1 - i);
            #1;
            chk(a0 == ref_mem[i], "R8 port0", a0, ref_mem[i]);
            chk(a1 == ref_mem[DEPTH-1-i], "R1 port1", a1, ref_mem[DEPTH-1-i]);
            chk(b0 == ref_mem[i], "R2 copy u1", b0, ref_mem[i]);
        end
    endtask

    // R3: read data follows address inside one clock phase
    task automatic t_async();
        @(negedge clk);
        rd0_addr = 5'd3; #1;
        chk(a0 == ref_mem[3], "R3 addr3", a0, ref_mem[3]);
        rd0_addr = 5'd7; #1;
        chk(a0 == ref_mem[7], "R3 addr7", a0, ref_mem[7]);
        rd1_addr = 5'd12; #1;
        chk(a1 == ref_mem[12], "R3 addr12", a1, ref_mem[12]);
    endtask

    // R6: write data and address without enable change nothing
    task automatic t_no_enable();
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd4; wr_data = 16'hFFFF;
        rd0_addr = 5'd4; rd1_addr = 5'd4;
        repeat (2) @(negedge clk);
        #1;
        chk(a0 == ref_mem[4], "R6 port0", a0, ref_mem[4]);
        chk(a1 == ref_mem[4], "R6 port1", a1, ref_mem[4]);
    endtask

    // R4, R5: same-cycle collision between a read and the write
    task automatic t_collision();
        logic [WIDTH-1:0] old_v;
        old_v = ref_mem[5];
        @(negedge clk);
        rd0_addr = 5'd5; rd1_addr = 5'd5;
        wr_en = 1'b1; wr_addr = 5'd5; wr_data = 16'hC0DE;
        #1;
        chk(a0 == old_v, "R4 old value", a0, old_v);
        chk(b1 == 16'hC0DE, "R5 write-through", b1, 16'hC0DE);
        @(negedge clk);
        wr_en = 1'b0;
        ref_mem[5] = 16'hC0DE;
        #1;
        chk(a0 == 16'hC0DE, "R4 after edge", a0, 16'hC0DE);
        chk(b0 == 16'hC0DE, "R5 after edge", b0, 16'hC0DE);
    endtask

    // R7, R10: writes during reset ignored; contents survive reset
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = 16'h1234;
        rd1_addr = 5'd9;
        #1;
        chk(b1 == ref_mem[9], "R7 no bypass in reset", b1, ref_mem[9]);
        repeat (3) @(negedge clk);
        wr_en = 1'b0; rst = 1'b0;
        rd0_addr = 5'd9; rd1_addr = 5'd10;
        #1;
        chk(a0 == ref_mem[9], "R7 write ignored", a0, ref_mem[9]);
        chk(a1 == ref_mem[10], "R10 kept over reset", a1, ref_mem[10]);
    endtask

    // R9: both ports on the same address agree
    task automatic t_same_addr();
        for (int i = 0; i < DEPTH; i += 5) begin
            @(negedge clk);
            rd0_addr = AW'(i); rd1_addr = AW'(i);
            #1;
            chk(a0 == a1, "R9 ports agree", a1, a0);
            chk(a1 == ref_mem[i], "R9 value", a1, ref_mem[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_fill_all();
        t_async();
        t_no_enable();
        t_collision();
        t_reset();
        t_same_addr();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule